// File: doc/BRIEF.md
# Three-Port Path-Addressed Packet Switch

This block connects three character-level network ports through one shared datapath. Each port offers a receive FIFO read side and a transmit FIFO write side. When a packet is waiting at an input, the controller picks that input and reads its first byte, which is the path address. That byte gives the number of the output port and is not forwarded. The controller then moves the rest of the packet, one character per cycle, to the selected output. It keeps the connection open until the packet's end marker has passed, and only then returns to serve another input.

A packet is one address byte, then zero or more cargo bytes, then an end marker. A character whose control flag is set is an end marker. Data bit 0 of that character tells a normal end (0) from an error end (1). The controller has five states: port reset, idle, source selection, destination selection (which also deletes the address byte) and forwarding. Only one port-to-port connection exists at any time.

Top module: `pkt_switch3`

## Requirements
- R1: While reset is applied, `port_rst` is high and no read or write strobe is active. On the first clock edge after reset is released, the controller goes idle and `port_rst` drops.
- R2: When more than one input is non-empty while the controller is idle, the lowest-numbered input is served first. The other packets wait until that packet has ended.
- R3: The first byte of a packet selects the output port (0, 1 or 2) and is not forwarded. The cargo bytes leave that output in their original order.
- R4: At most one receive read strobe and at most one transmit write strobe are active in any cycle. Bytes of two packets never interleave at an output.
- R5: A character moves only when the source FIFO is not empty and the destination FIFO is not full. The read and the write of a character happen in the same cycle. While the destination is full, nothing is written.
- R6: The end marker (control flag 1; data bit 0 = 0 for normal end, 1 for error end) is forwarded with its data byte unchanged. In the cycle after it is written, no strobe is active.
- R7: If the address byte is 3 or greater, every character up to and including the end marker is read from the source and discarded. Nothing is written to any output.
- R8: If the first character of a packet is an end marker, it is read and discarded, nothing is written, and the next packet on that input is handled normally.
- R9: A packet with no cargo bytes produces exactly one character at its output: the end marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_rst | output | 1 | Reset request to the network ports |
| rx_data | input | NPORT*DW | Head data byte of each receive FIFO, port p at bits [p*DW +: DW] |
| rx_ctrl | input | NPORT | Control flag of each receive FIFO head |
| rx_empty | input | NPORT | Receive FIFO empty, one bit per port |
| rx_rd | output | NPORT | Receive FIFO read (pop), one bit per port |
| tx_data | output | DW | Shared transmit data byte |
| tx_ctrl | output | 1 | Shared transmit control flag |
| tx_full | input | NPORT | Transmit FIFO full, one bit per port |
| tx_wr | output | NPORT | Transmit FIFO write, one bit per port |

## Verification
On every cycle, the assertions check the strobe rules. They check that a write never goes to a full FIFO, that a read never pops an empty one, that at most one read and one write are active, that every write has a read in the same cycle, and that the controller goes quiet after an end marker and during reset. Other behaviour can only be shown by the bench's scenarios, which compare the byte stream at each output with the packet that was sent. These are header deletion, routing to the addressed port, the order in which competing inputs are served, discarding packets with a bad address or an empty header, and the pause and resume when a destination fills.

// File: rtl/pkt_switch3.sv
module pkt_switch3 #(
  parameter int NPORT = 3,
  parameter int DW    = 8,
  localparam int SW   = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic                port_rst,
  input  logic [NPORT*DW-1:0] rx_data,
  input  logic [NPORT-1:0]    rx_ctrl,
  input  logic [NPORT-1:0]    rx_empty,
  output logic [NPORT-1:0]    rx_rd,
  output logic [DW-1:0]       tx_data,
  output logic                tx_ctrl,
  input  logic [NPORT-1:0]    tx_full,
  output logic [NPORT-1:0]    tx_wr
);

  typedef enum logic [2:0] {S_RST, S_IDLE, S_SRC, S_DST, S_FWD} st_t;
  st_t st, st_nx;

  logic [SW-1:0] pick, src_q, dst_idx;
  logic [DW-1:0] dst_q, cur_data;
  logic          cur_ctrl, src_rdy, dst_ok, move, hdr_del;

  always_comb begin
    pick = '0;
    for (int i = NPORT - 1; i >= 0; i--)
      if (!rx_empty[i]) pick = SW'(i);
  end

  assign cur_data = rx_data[src_q*DW +: DW];
  assign cur_ctrl = rx_ctrl[src_q];
  assign src_rdy  = !rx_empty[src_q];
  assign dst_ok   = dst_q < DW'(NPORT);
  assign dst_idx  = dst_q[SW-1:0];
  assign hdr_del  = (st == S_DST) && src_rdy;
  assign move     = (st == S_FWD) && src_rdy && (!dst_ok || !tx_full[dst_idx]);

  assign port_rst = (st == S_RST);
  assign rx_rd    = (hdr_del || move) ? (NPORT'(1) << src_q) : '0;
  assign tx_wr    = (move && dst_ok) ? (NPORT'(1) << dst_idx) : '0;
  assign tx_data  = cur_data;
  assign tx_ctrl  = cur_ctrl;

  always_comb begin
    st_nx = st;
    case (st)
      S_RST:   st_nx = S_IDLE;
      S_IDLE:  if (|(~rx_empty)) st_nx = S_SRC;
      S_SRC:   st_nx = S_DST;
      S_DST:   if (src_rdy) st_nx = cur_ctrl ? S_IDLE : S_FWD;
      S_FWD:   if (move && cur_ctrl) st_nx = S_IDLE;
      default: st_nx = S_RST;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_RST;
      src_q <= '0;
      dst_q <= '0;
    end else begin
      st <= st_nx;
      if (st == S_SRC) src_q <= pick;
      if (hdr_del)     dst_q <= cur_data;
    end
  end

  p_no_write_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr & tx_full) == '0);
  p_no_read_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd & rx_empty) == '0);
  p_write_has_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|tx_wr) |-> (|rx_rd));
  p_one_conn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rx_rd) && $onehot0(tx_wr));
  p_quiet_after_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((|tx_wr) && tx_ctrl) |=> (tx_wr == '0 && rx_rd == '0));
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    port_rst |-> (tx_wr == '0 && rx_rd == '0));

endmodule

// File: tb/sim_pkt_switch3.sv
module sim_pkt_switch3;
  localparam int NP = 3;
  localparam int RD = 256;
  localparam int TD = 1024;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          port_rst;
  logic [NP*8-1:0] rx_data;
  logic [NP-1:0] rx_ctrl, rx_empty, rx_rd, tx_full, tx_wr;
  logic [7:0]    tx_data;
  logic          tx_ctrl;

  always #5 clk = ~clk;

  pkt_switch3 #(.NPORT(NP), .DW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .port_rst(port_rst),
    .rx_data(rx_data), .rx_ctrl(rx_ctrl), .rx_empty(rx_empty), .rx_rd(rx_rd),
    .tx_data(tx_data), .tx_ctrl(tx_ctrl), .tx_full(tx_full), .tx_wr(tx_wr));

  logic [8:0] rxm [NP][RD];
  int         rx_wp [NP];
  int         rx_rp [NP];
  logic [8:0] txm [NP][TD];
  int         tx_n [NP];

  int tests = 0, fails = 0, cyc = 0;

  initial begin
    for (int p = 0; p < NP; p++) begin
      rx_wp[p] = 0; rx_rp[p] = 0; tx_n[p] = 0;
    end
    tx_full = '0;
  end

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      rx_empty[p]        = (rx_wp[p] == rx_rp[p]);
      rx_ctrl[p]         = rxm[p][rx_rp[p] % RD][8];
      rx_data[p*8 +: 8]  = rxm[p][rx_rp[p] % RD][7:0];
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    for (int p = 0; p < NP; p++) begin
      if (rx_rd[p]) rx_rp[p] <= rx_rp[p] + 1;
      if (tx_wr[p]) begin
        txm[p][tx_n[p] % TD] <= {tx_ctrl, tx_data};
        tx_n[p] <= tx_n[p] + 1;
      end
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(negedge clk) if (cyc > 100000) begin
    fails = fails + 1;
    $display("FAIL watchdog: act=%0d cycles exp<=100000", cyc);
    summary();
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic push(input int p, input logic [8:0] ch);
    rxm[p][rx_wp[p] % RD] = ch;
    rx_wp[p] = rx_wp[p] + 1;
  endtask

  task automatic push_pkt(input int p, input logic [7:0] addr, input int len,
                          input logic [7:0] base, input bit eep);
    push(p, {1'b0, addr});
    for (int i = 0; i < len; i++) push(p, {1'b0, 8'(base + i)});
    push(p, {1'b1, 7'd0, eep});
  endtask

  task automatic drain();
    int n = 0;
    while ((rx_wp[0] != rx_rp[0] || rx_wp[1] != rx_rp[1] || rx_wp[2] != rx_rp[2]) && n < 3000) begin
      @(negedge clk); n++;
    end
    repeat (4) @(negedge clk);
  endtask

  // {src[22:21], addr[20:13], len[12:9], base[8:1], eep[0]}
  localparam logic [22:0] VEC [8] = '{
    {2'd0, 8'd1,   4'd3,  8'h10, 1'b0},
    {2'd1, 8'd2,   4'd5,  8'h20, 1'b1},
    {2'd2, 8'd0,   4'd1,  8'h30, 1'b0},
    {2'd0, 8'd0,   4'd2,  8'h40, 1'b0},
    {2'd1, 8'd1,   4'd0,  8'h00, 1'b1},
    {2'd2, 8'd3,   4'd4,  8'h50, 1'b0},
    {2'd0, 8'hFF,  4'd2,  8'h60, 1'b1},
    {2'd2, 8'd1,   4'd15, 8'h70, 1'b0}
  };

  initial begin
    int snap [NP];
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(port_rst == 1'b1, "R1 port_rst in reset", port_rst, 1);
    chk(rx_rd == '0 && tx_wr == '0, "R1 strobes in reset", {rx_rd, tx_wr}, 0);
    // R2: two packets waiting before reset release, both to port 0
    push_pkt(2, 8'd0, 2, 8'h80, 1'b0);
    push_pkt(1, 8'd0, 2, 8'h90, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(port_rst == 1'b0, "R1 port_rst after release", port_rst, 0);
    drain();
    chk(tx_n[0] == 6, "R2 count on port 0", tx_n[0], 6);
    chk(txm[0][0] == 9'h090 && txm[0][1] == 9'h091 && txm[0][2] == 9'h101,
        "R2 lowest input first", txm[0][0], 9'h090);
    chk(txm[0][3] == 9'h080 && txm[0][4] == 9'h081 && txm[0][5] == 9'h100,
        "R4 second packet after first", txm[0][3], 9'h080);

    // Vector table: R3 R6 R7 R9
    for (int v = 0; v < 8; v++) begin
      int s, a, l, b, e;
      s = int'(VEC[v][22:21]); a = int'(VEC[v][20:13]); l = int'(VEC[v][12:9]);
      b = int'(VEC[v][8:1]);   e = int'(VEC[v][0]);
      for (int p = 0; p < NP; p++) snap[p] = tx_n[p];
      push_pkt(s, 8'(a), l, 8'(b), e[0]);
      drain();
      for (int p = 0; p < NP; p++) begin
        int ex;
        ex = (p == a) ? l + 1 : 0;
        chk(tx_n[p] - snap[p] == ex, (a >= NP) ? "R7 nothing written" : "R3 output count",
            tx_n[p] - snap[p], ex);
      end
      if (a < NP) begin
        for (int i = 0; i < l; i++)
          chk(txm[a][(snap[a] + i) % TD] == {1'b0, 8'(b + i)}, "R3 cargo byte",
              txm[a][(snap[a] + i) % TD], {1'b0, 8'(b + i)});
        chk(txm[a][(snap[a] + l) % TD] == {1'b1, 7'd0, e[0]},
            (l == 0) ? "R9 marker only" : "R6 end marker", txm[a][(snap[a] + l) % TD],
            {1'b1, 7'd0, e[0]});
      end
    end

    // R5: destination full holds the transfer
    for (int p = 0; p < NP; p++) snap[p] = tx_n[p];
    tx_full[2] = 1'b1;
    push_pkt(0, 8'd2, 3, 8'hB0, 1'b0);
    repeat (12) @(negedge clk);
    chk(tx_n[2] == snap[2], "R5 no write while full", tx_n[2] - snap[2], 0);
    chk(rx_wp[0] - rx_rp[0] == 4, "R5 source held", rx_wp[0] - rx_rp[0], 4);
    tx_full[2] = 1'b0;
    @(negedge clk); @(negedge clk);
    tx_full[2] = 1'b1;
    repeat (6) @(negedge clk);
    chk(tx_n[2] - snap[2] == 2, "R5 stall mid-packet", tx_n[2] - snap[2], 2);
    tx_full[2] = 1'b0;
    drain();
    chk(tx_n[2] - snap[2] == 4, "R5 resume count", tx_n[2] - snap[2], 4);
    chk(txm[2][(snap[2] + 2) % TD] == 9'h0B2 && txm[2][(snap[2] + 3) % TD] == 9'h100,
        "R5 resume content", txm[2][(snap[2] + 2) % TD], 9'h0B2);

    // R8: leading end marker discarded, next packet normal
    for (int p = 0; p < NP; p++) snap[p] = tx_n[p];
    push(1, 9'h101);
    push_pkt(1, 8'd2, 1, 8'hA0, 1'b0);
    drain();
    chk(tx_n[0] == snap[0] && tx_n[1] == snap[1], "R8 no stray write",
        tx_n[0] + tx_n[1] - snap[0] - snap[1], 0);
    chk(tx_n[2] - snap[2] == 2, "R8 next packet count", tx_n[2] - snap[2], 2);
    chk(txm[2][snap[2] % TD] == 9'h0A0, "R8 next packet data", txm[2][snap[2] % TD], 9'h0A0);

    summary();
  end
endmodule